// File: doc/BRIEF.md
# Multi-Source Reset Generator

This block merges several reset causes into a single system reset that stays active for a fixed minimum time after the last cause goes away. Three causes are levels: a supply-below-threshold flag, an active-low push-button input, and an active-low flag from an auxiliary comparator. While any of them is active, reset is held. The fourth cause is a one-cycle watchdog expiry strobe. That strobe starts a single reset pulse of the timeout length.

The three level inputs are asynchronous. Each passes through a chain of synchronizing flops. The push-button path also runs through a glitch filter, so a short bounce or noise spike cannot reset the system. A bare momentary switch can drive that input directly. One down-counter sets the hold time. Any active cause reloads it to the timeout length. Reset is active whenever the counter is not zero.

Reset comes out in both polarities. A third copy serves as an internal flag for neighbouring chip-enable gating and watchdog logic. At power-on the counter starts full, so reset is active from time zero and lasts one full timeout before it first releases.

Top module: `reset_combiner`

## Requirements
- R1: From power-on, reset is active. It releases after exactly TIMEOUT_CYCLES rising clock edges when no cause is present.
- R2: A high level on `supplyLow` activates reset. The active state is visible after the third rising edge that follows the input change.
- R3: A low level on `auxOkN` (0 = auxiliary input below its reference) activates reset while it is held.
- R4: Holding `manRstN` low for at least FILTER_CYCLES + 1 cycles activates reset. After `manRstN` returns high, reset releases FILTER_CYCLES + TIMEOUT_CYCLES + 2 edges later.
- R5: A low pulse on `manRstN` shorter than FILTER_CYCLES cycles has no effect on the reset outputs.
- R6: When a level cause clears, reset releases exactly TIMEOUT_CYCLES + 2 rising edges after the input change. The 2 edges are the synchronizer delay.
- R7: A one-cycle high on `wdTimeout` while reset is idle produces one reset pulse lasting exactly TIMEOUT_CYCLES cycles.
- R8: A watchdog strobe that arrives while reset is already active restarts the full timeout.
- R9: `rstN` is always the inverse of `rstHi`, and `rstActive` always equals `rstHi`.
- R10: When several level causes overlap, the release time is measured from the last cause to clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| supplyLow | input | 1 | Asynchronous; 1 = supply below threshold |
| manRstN | input | 1 | Asynchronous push-button reset, active low |
| auxOkN | input | 1 | Asynchronous auxiliary comparator flag, 0 = below reference |
| wdTimeout | input | 1 | Synchronous one-cycle watchdog expiry strobe |
| rstN | output | 1 | Reset, active low |
| rstHi | output | 1 | Reset, active high |
| rstActive | output | 1 | Internal reset-active flag for gating and watchdog logic |

## Verification
The assertions assume that `wdTimeout` is already synchronous to `clk` and lasts exactly one cycle. They also assume that each level input holds a value for several clock periods, so the synchronizers settle. The bench drives every input on the falling edge of the clock and raises the strobe for exactly one period. Level inputs are held for many cycles, except in the deliberate glitch test on the push-button input. That short pulse is still whole clock periods long, so the filter counter sees a clean run of mismatched samples.

// File: rtl/rc_pkg.sv
package rc_pkg;
  // Control-to-datapath strobes for the hold-time counter
  typedef struct packed {
    logic reload;  // load the full timeout
    logic step;    // count down by one
  } rcStrobe_t;
endpackage

// File: rtl/rc_sync.sv
module rc_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain = {STAGES{INIT[i]}};
    always_ff @(posedge clk) chain <= {chain[STAGES-2:0], din[i]};
    assign dout[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/rc_glitch_filter.sv
module rc_glitch_filter #(
  parameter int FILTER_CYCLES = 16
) (
  input  logic clk,
  input  logic rawN,
  output logic levelN
);
  localparam int CW = $clog2(FILTER_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILTER_CYCLES - 1);

  logic          stateN = 1'b1;
  logic [CW-1:0] runCnt = '0;
  logic          chkArmed = 1'b0;

  always_ff @(posedge clk) begin
    if (rawN == stateN) begin
      runCnt <= '0;
    end else if (runCnt == LAST) begin
      stateN <= rawN;
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + CW'(1);
    end
  end

  assign levelN = stateN;

  always_ff @(posedge clk) chkArmed <= 1'b1;

  // R5
  flip_needs_mismatch_chk: assert property (@(posedge clk) disable iff (!chkArmed)
    (stateN != $past(stateN)) |-> ($past(rawN) != $past(stateN)));

  // R5
  flip_needs_full_run_chk: assert property (@(posedge clk) disable iff (!chkArmed)
    (stateN != $past(stateN)) |-> ($past(runCnt) == LAST));
endmodule

// File: rtl/rc_control.sv
module rc_control
  import rc_pkg::*;
(
  input  logic       supplyLowS,
  input  logic       manFiltN,
  input  logic       auxOkS,
  input  logic       wdTimeout,
  input  logic       countZero,
  output rcStrobe_t  strobe
);
  logic levelCause;

  always_comb begin
    levelCause    = supplyLowS | ~manFiltN | ~auxOkS;
    strobe.reload = levelCause | wdTimeout;
    strobe.step   = ~strobe.reload & ~countZero;
  end
endmodule

// File: rtl/rc_datapath.sv
module rc_datapath
  import rc_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic      clk,
  input  rcStrobe_t strobe,
  output logic      countZero
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(TIMEOUT_CYCLES);

  logic [CW-1:0] holdCnt = FULL;
  logic          chkArmed = 1'b0;

  always_ff @(posedge clk) begin
    if (strobe.reload) holdCnt <= FULL;
    else if (strobe.step) holdCnt <= holdCnt - CW'(1);
  end

  assign countZero = (holdCnt == '0);

  always_ff @(posedge clk) chkArmed <= 1'b1;

  // R8
  reload_full_chk: assert property (@(posedge clk) disable iff (!chkArmed)
    strobe.reload |=> (holdCnt == FULL));

  // R6
  step_by_one_chk: assert property (@(posedge clk) disable iff (!chkArmed)
    strobe.step |=> (holdCnt == $past(holdCnt) - CW'(1)));

  // R7
  idle_stays_chk: assert property (@(posedge clk) disable iff (!chkArmed)
    (!strobe.reload && countZero) |=> countZero);
endmodule

// File: rtl/reset_combiner.sv
module reset_combiner
  import rc_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int FILTER_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic supplyLow,
  input  logic manRstN,
  input  logic auxOkN,
  input  logic wdTimeout,
  output logic rstN,
  output logic rstHi,
  output logic rstActive
);
  logic [2:0] syncOut;
  logic       manFiltN;
  logic       countZero;
  rcStrobe_t  strobe;
  logic       chkArmed = 1'b0;

  // bit 2 supply (idle 0), bit 1 manual (idle 1), bit 0 aux (idle 1)
  rc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b011)) u_sync (
    .clk (clk),
    .din ({supplyLow, manRstN, auxOkN}),
    .dout(syncOut)
  );

  rc_glitch_filter #(.FILTER_CYCLES(FILTER_CYCLES)) u_filt (
    .clk   (clk),
    .rawN  (syncOut[1]),
    .levelN(manFiltN)
  );

  rc_control u_ctrl (
    .supplyLowS(syncOut[2]),
    .manFiltN  (manFiltN),
    .auxOkS    (syncOut[0]),
    .wdTimeout (wdTimeout),
    .countZero (countZero),
    .strobe    (strobe)
  );

  rc_datapath #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .countZero(countZero)
  );

  assign rstActive = ~countZero;
  assign rstHi     = ~countZero;
  assign rstN      = countZero;

  always_ff @(posedge clk) chkArmed <= 1'b1;

  // R2
  supply_forces_reset_chk: assert property (@(posedge clk) disable iff (!chkArmed)
    syncOut[2] |=> rstActive);

  // R3
  aux_forces_reset_chk: assert property (@(posedge clk) disable iff (!chkArmed)
    !syncOut[0] |=> rstActive);

  // R7
  strobe_forces_reset_chk: assert property (@(posedge clk) disable iff (!chkArmed)
    wdTimeout |=> !rstN);
endmodule

// File: tb/sim_reset_combiner.sv
module sim_reset_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int T = 50;
  localparam int F = 5;

  logic clk = 1'b0;
  logic supplyLow = 1'b0;
  logic manRstN = 1'b1;
  logic auxOkN = 1'b1;
  logic wdTimeout = 1'b0;
  logic rstN, rstHi, rstActive;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  reset_combiner #(.TIMEOUT_CYCLES(T), .FILTER_CYCLES(F), .SYNC_STAGES(2)) u0 (
    .clk(clk), .supplyLow(supplyLow), .manRstN(manRstN), .auxOkN(auxOkN),
    .wdTimeout(wdTimeout), .rstN(rstN), .rstHi(rstHi), .rstActive(rstActive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkPolarity(input string req);
    check(req, int'(rstN == ~rstHi && rstActive == rstHi), 1);
  endtask

  // counts falling edges (starting with the current one) where reset is active
  task automatic countHigh(output int n);
    n = 0;
    while (rstHi && n < 4 * T + 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic testPowerOn();
    int n = 0;
    #1;
    check("R1 reset at time zero", int'(rstHi), 1);
    checkPolarity("R9 power-on");
    @(negedge clk);
    countHigh(n);
    check("R1 power-on length", n, T - 1);
    checkPolarity("R9 after release");
  endtask

  task automatic testSupply();
    int n = 0;
    @(negedge clk) supplyLow = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 not yet at second edge", int'(rstHi), 0);
    @(negedge clk);
    check("R2 supply low asserts", int'(rstHi), 1);
    checkPolarity("R9 supply");
    repeat (10) @(negedge clk);
    supplyLow = 1'b0;
    countHigh(n);
    check("R6 release after supply", n, T + 2);
  endtask

  task automatic testAux();
    int n = 0;
    @(negedge clk) auxOkN = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 aux low asserts", int'(rstHi), 1);
    repeat (T + 20) @(negedge clk);
    check("R3 aux held keeps reset", int'(rstHi), 1);
    auxOkN = 1'b1;
    countHigh(n);
    check("R6 release after aux", n, T + 2);
  endtask

  task automatic testGlitch();
    int seen = 0;
    @(negedge clk) manRstN = 1'b0;
    repeat (F - 1) @(negedge clk);
    manRstN = 1'b1;
    for (int i = 0; i < 2 * F + 10; i++) begin
      @(negedge clk);
      if (rstHi) seen++;
    end
    check("R5 short manual pulse ignored", seen, 0);
  endtask

  task automatic testManual();
    int n = 0;
    @(negedge clk) manRstN = 1'b0;
    repeat (3 * F) @(negedge clk);
    check("R4 manual held asserts", int'(rstHi), 1);
    manRstN = 1'b1;
    countHigh(n);
    check("R4 manual release time", n, F + T + 2);
  endtask

  task automatic testWatchdog();
    int n = 0;
    @(negedge clk) wdTimeout = 1'b1;
    @(negedge clk) wdTimeout = 1'b0;
    countHigh(n);
    check("R7 watchdog pulse length", n, T);
    repeat (20) @(negedge clk);
    check("R7 single pulse only", int'(rstHi), 0);
  endtask

  task automatic testRetrigger();
    int n = 0;
    @(negedge clk) wdTimeout = 1'b1;
    @(negedge clk) wdTimeout = 1'b0;
    repeat (10) @(negedge clk);
    wdTimeout = 1'b1;
    @(negedge clk) wdTimeout = 1'b0;
    countHigh(n);
    check("R8 retrigger restarts timeout", n, T);
  endtask

  task automatic testOverlap();
    int n = 0;
    int drop = 0;
    @(negedge clk) begin supplyLow = 1'b1; auxOkN = 1'b0; end
    repeat (5) @(negedge clk);
    supplyLow = 1'b0;
    for (int i = 0; i < T + 10; i++) begin
      @(negedge clk);
      if (!rstHi) drop++;
    end
    check("R10 held by remaining cause", drop, 0);
    auxOkN = 1'b1;
    countHigh(n);
    check("R10 release from last cause", n, T + 2);
    checkPolarity("R9 idle");
  endtask

  initial begin
    testPowerOn();
    testSupply();
    testAux();
    testGlitch();
    testManual();
    testWatchdog();
    testRetrigger();
    testOverlap();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule